// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block adds or subtracts two operands and produces the result together with six status bits: carry, signed overflow, sign, zero, auxiliary (nibble) carry and even parity. One operation is used for both the unsigned and the signed reading of the operands. Carry covers the unsigned reading and overflow covers the signed one, so each can be set without the other.

The operands and the add/subtract select are sampled on a rising clock edge while the enable is high. The result and all six status bits are registered together and appear after that edge. While the enable is low, the registered values are held. The reset input is asynchronous and active low. Its assertion clears the registers at once. Its release passes through a two-stage synchroniser before the registers respond to it.

Top module: `arith_flag_unit`

## Requirements
- R1: While reset is active, the result and all six status outputs are 0.
- R2: When `en` is high at a rising edge, `result` becomes `op_a + op_b` modulo 256 if `sub` = 0, or `op_a - op_b` modulo 256 if `sub` = 1. The new value is visible after that edge.
- R3: When `en` is low at a rising edge, `result` and all six status outputs keep their values, whatever the operands and `sub` do.
- R4: `flag_c` is the unsigned out-of-range indication. For an add it is 1 when `op_a + op_b` > 255. For a subtract it is 1 (a borrow) when `op_a` < `op_b`.
- R5: `flag_v` is the signed out-of-range indication, with both operands read in two's complement. It is 1 when the exact signed sum (or difference) lies outside -128..127. For an add, this means two operands of equal sign give a result of the other sign.
- R6: `flag_s` equals bit 7 of the registered result.
- R7: `flag_z` is 1 exactly when the registered result is 0.
- R8: `flag_a` is the carry out of bit 3 into bit 4. For an add it is 1 when `op_a[3:0] + op_b[3:0]` > 15. For a subtract it is 1 when `op_a[3:0]` < `op_b[3:0]`.
- R9: `flag_p` is 1 when bits 7..0 of the result hold an even number of ones.
- R10: Carry and overflow are independent, and all four combinations occur. 79+64 gives C=0 V=1. 157+218 gives C=1 V=1. 15+8 gives C=0 V=0. 245+15 gives C=1 V=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| en | input | 1 | Load enable for result and status |
| sub | input | 1 | 0 = add, 1 = subtract (op_a - op_b) |
| op_a | input | 8 | First operand / minuend |
| op_b | input | 8 | Second operand / subtrahend |
| result | output | 8 | Registered sum or difference |
| flag_c | output | 1 | Carry / borrow |
| flag_v | output | 1 | Signed overflow |
| flag_s | output | 1 | Sign (result bit 7) |
| flag_z | output | 1 | Result is zero |
| flag_a | output | 1 | Auxiliary carry out of bit 3 |
| flag_p | output | 1 | Even parity of the result |

## Verification
The four carry/overflow operand pairs show that the two range checks are separate. A wrong rule for either one makes at least one of the four pairs fail. Subtractions with the minuend below, equal to and above the subtrahend test the borrow sense of carry. The same cases cover the zero result and the overflow from mixed signs. Nibble-boundary sums and differences separate the auxiliary carry from the full carry. A sweep over many operand pairs compares every output with a model that uses wider integers, and results with odd and even ones-counts test parity.

// File: rtl/afu_pkg.sv
package afu_pkg;
  typedef struct packed {
    logic carry;
    logic ovf;
    logic sign;
    logic zero;
    logic aux;
    logic par;
  } afu_flags_t;

  localparam int unsigned AFU_PAR_W = 8;
endpackage

// File: rtl/afu_rst_sync.sv
module afu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/afu_addsub.sv
module afu_addsub #(
  parameter int unsigned W   = 8,
  parameter int unsigned NIB = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         c_nib,
  output logic         c_msb_in,
  output logic         c_out
);
  localparam int unsigned MID_W = W - 1 - NIB;

  logic [W-1:0]     b_eff;
  logic [NIB:0]     lo;
  logic [MID_W:0]   mid;
  logic [1:0]       top;

  always_comb begin
    b_eff = sub ? ~b : b;
    lo  = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, sub};
    mid = {1'b0, a[W-2:NIB]} + {1'b0, b_eff[W-2:NIB]} + {{MID_W{1'b0}}, lo[NIB]};
    top = {1'b0, a[W-1]} + {1'b0, b_eff[W-1]} + {1'b0, mid[MID_W]};
    sum      = {top[0], mid[MID_W-1:0], lo[NIB-1:0]};
    c_nib    = lo[NIB];
    c_msb_in = mid[MID_W];
    c_out    = top[1];
  end
endmodule

// File: rtl/afu_flagcalc.sv
module afu_flagcalc
  import afu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] sum,
  input  logic         sub,
  input  logic         c_nib,
  input  logic         c_msb_in,
  input  logic         c_out,
  output afu_flags_t   flags
);
  always_comb begin
    flags.carry = c_out ^ sub;
    flags.aux   = c_nib ^ sub;
    flags.ovf   = c_msb_in ^ c_out;
    flags.sign  = sum[W-1];
    flags.zero  = ~|sum;
    flags.par   = ~^sum[AFU_PAR_W-1:0];
  end
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import afu_pkg::*;
#(
  parameter int unsigned W   = 8,
  parameter int unsigned NIB = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         sub,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] result,
  output logic         flag_c,
  output logic         flag_v,
  output logic         flag_s,
  output logic         flag_z,
  output logic         flag_a,
  output logic         flag_p
);
  logic         rst_sync_n;
  logic [W-1:0] sum;
  logic         c_nib, c_msb_in, c_out;
  afu_flags_t   flags_nx, flags_q, flags_d;
  logic [W-1:0] res_q, res_d;

  afu_rst_sync #(.STAGES(2)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  afu_addsub #(.W(W), .NIB(NIB)) u_add (
    .a(op_a), .b(op_b), .sub(sub), .sum(sum),
    .c_nib(c_nib), .c_msb_in(c_msb_in), .c_out(c_out)
  );

  afu_flagcalc #(.W(W)) u_flg (
    .sum(sum), .sub(sub), .c_nib(c_nib), .c_msb_in(c_msb_in),
    .c_out(c_out), .flags(flags_nx)
  );

  always_comb begin
    res_d   = res_q;
    flags_d = flags_q;
    if (en) begin
      res_d   = sum;
      flags_d = flags_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q   <= '0;
      flags_q <= '0;
    end else begin
      res_q   <= res_d;
      flags_q <= flags_d;
    end
  end

  assign result = res_q;
  assign flag_c = flags_q.carry;
  assign flag_v = flags_q.ovf;
  assign flag_s = flags_q.sign;
  assign flag_z = flags_q.zero;
  assign flag_a = flags_q.aux;
  assign flag_p = flags_q.par;
endmodule

// File: rtl/afu_checker.sv
module afu_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_sync_n,
  input logic         en,
  input logic         sub,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [W-1:0] result,
  input logic         flag_c,
  input logic         flag_v,
  input logic         flag_s,
  input logic         flag_z,
  input logic         flag_a,
  input logic         flag_p
);
  logic         armed_q;
  logic [W-1:0] exp_res;
  logic         exp_c, exp_v;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) armed_q <= 1'b0;
    else             armed_q <= 1'b1;
  end

  always_comb begin
    if (sub) begin
      exp_res = op_a - op_b;
      exp_c   = (op_a < op_b);
      exp_v   = (op_a[W-1] != op_b[W-1]) && (exp_res[W-1] != op_a[W-1]);
    end else begin
      exp_res = op_a + op_b;
      exp_c   = (exp_res < op_a);
      exp_v   = (op_a[W-1] == op_b[W-1]) && (exp_res[W-1] != op_a[W-1]);
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (result == '0) && !flag_c && !flag_v && !flag_s && !flag_z && !flag_a && !flag_p);

  // R2
  load_result_chk: assert property (@(posedge clk) disable iff (!armed_q)
    $past(en) |-> result == $past(exp_res));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!armed_q)
    !$past(en) |-> $stable(result) && $stable(flag_c) && $stable(flag_v) && $stable(flag_s)
                   && $stable(flag_z) && $stable(flag_a) && $stable(flag_p));

  // R4
  carry_chk: assert property (@(posedge clk) disable iff (!armed_q)
    $past(en) |-> flag_c == $past(exp_c));

  // R5
  overflow_chk: assert property (@(posedge clk) disable iff (!armed_q)
    $past(en) |-> flag_v == $past(exp_v));

  // R6
  sign_chk: assert property (@(posedge clk) disable iff (!armed_q)
    $past(en) |-> flag_s == result[W-1]);

  // R7
  zero_chk: assert property (@(posedge clk) disable iff (!armed_q)
    $past(en) |-> flag_z == (result == '0));

  // R9
  parity_chk: assert property (@(posedge clk) disable iff (!armed_q)
    $past(en) |-> flag_p == ($countones(result[7:0]) % 2 == 0));
endmodule

bind arith_flag_unit afu_checker #(.W(W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .en(en), .sub(sub),
  .op_a(op_a), .op_b(op_b), .result(result),
  .flag_c(flag_c), .flag_v(flag_v), .flag_s(flag_s),
  .flag_z(flag_z), .flag_a(flag_a), .flag_p(flag_p)
);

// File: tb/arith_flag_unit_tb.sv
module arith_flag_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic       sub;
  logic [7:0] op_a, op_b;
  logic [7:0] result;
  logic       flag_c, flag_v, flag_s, flag_z, flag_a, flag_p;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  arith_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .sub(sub), .op_a(op_a), .op_b(op_b),
    .result(result), .flag_c(flag_c), .flag_v(flag_v), .flag_s(flag_s),
    .flag_z(flag_z), .flag_a(flag_a), .flag_p(flag_p)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // independent model, wider arithmetic
  task automatic expect_op(input logic [7:0] a, input logic [7:0] b, input logic s, input string tag);
    int ua = a, ub = b, sa = $signed(a), sb = $signed(b);
    int ur = s ? ua - ub : ua + ub;
    int sr = s ? sa - sb : sa + sb;
    logic [7:0] r = ur[7:0];
    check({tag, " R2"}, "result", result, r);
    check({tag, " R4"}, "carry", flag_c, s ? (ua < ub) : (ur > 255));
    check({tag, " R5"}, "overflow", flag_v, (sr > 127 || sr < -128));
    check({tag, " R6"}, "sign", flag_s, r[7]);
    check({tag, " R7"}, "zero", flag_z, r == 8'd0);
    check({tag, " R8"}, "aux", flag_a, s ? (a[3:0] < b[3:0]) : ((a[3:0] + b[3:0]) > 15));
    check({tag, " R9"}, "parity", flag_p, ($countones(r) % 2) == 0);
  endtask

  task automatic do_op(input logic [7:0] a, input logic [7:0] b, input logic s);
    @(negedge clk);
    op_a = a; op_b = b; sub = s; en = 1'b1;
    @(negedge clk);
    en = 1'b0;
  endtask

  task automatic reset_all_zero(input string tag);
    check({tag, " R1"}, "flags", {result, flag_c, flag_v, flag_s, flag_z, flag_a, flag_p}, 0);
  endtask

  task automatic t_reset();
    reset_all_zero("start");
    do_op(8'hFF, 8'h01, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    reset_all_zero("mid-run");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_four_cases();
    do_op(8'd79, 8'd64, 1'b0);
    check("R10", "C (79+64)", flag_c, 0); check("R10", "V (79+64)", flag_v, 1);
    expect_op(8'd79, 8'd64, 1'b0, "79+64");
    do_op(8'd157, 8'd218, 1'b0);
    check("R10", "C (157+218)", flag_c, 1); check("R10", "V (157+218)", flag_v, 1);
    expect_op(8'd157, 8'd218, 1'b0, "157+218");
    do_op(8'd15, 8'd8, 1'b0);
    check("R10", "C (15+8)", flag_c, 0); check("R10", "V (15+8)", flag_v, 0);
    expect_op(8'd15, 8'd8, 1'b0, "15+8");
    do_op(8'd245, 8'd15, 1'b0);
    check("R10", "C (245+15)", flag_c, 1); check("R10", "V (245+15)", flag_v, 0);
    expect_op(8'd245, 8'd15, 1'b0, "245+15");
  endtask

  task automatic t_subtract();
    do_op(8'd5, 8'd9, 1'b1);
    check("R4", "borrow 5-9", flag_c, 1);
    expect_op(8'd5, 8'd9, 1'b1, "5-9");
    do_op(8'd77, 8'd77, 1'b1);
    check("R7", "zero 77-77", flag_z, 1);
    expect_op(8'd77, 8'd77, 1'b1, "77-77");
    do_op(8'h80, 8'h01, 1'b1);
    check("R5", "ovf -128-1", flag_v, 1);
    expect_op(8'h80, 8'h01, 1'b1, "-128-1");
    do_op(8'h7F, 8'hFF, 1'b1);
    check("R5", "ovf 127-(-1)", flag_v, 1);
    expect_op(8'h7F, 8'hFF, 1'b1, "127+1 via sub");
  endtask

  task automatic t_nibble();
    do_op(8'h0F, 8'h01, 1'b0);
    check("R8", "aux 0F+01", flag_a, 1);
    check("R4", "no carry 0F+01", flag_c, 0);
    do_op(8'h10, 8'h01, 1'b1);
    check("R8", "aux borrow 10-01", flag_a, 1);
    do_op(8'h07, 8'h08, 1'b0);
    check("R8", "no aux 07+08", flag_a, 0);
  endtask

  task automatic t_parity_zero();
    do_op(8'h00, 8'h00, 1'b0);
    check("R9", "parity 00", flag_p, 1);
    check("R7", "zero 00", flag_z, 1);
    do_op(8'h01, 8'h00, 1'b0);
    check("R9", "parity 01", flag_p, 0);
    do_op(8'h80, 8'h00, 1'b0);
    check("R6", "sign 80", flag_s, 1);
    do_op(8'hFF, 8'h01, 1'b0);
    check("R7", "zero wrap", flag_z, 1);
    check("R4", "carry wrap", flag_c, 1);
  endtask

  task automatic t_hold();
    do_op(8'd200, 8'd100, 1'b0);
    @(negedge clk);
    op_a = 8'd1; op_b = 8'd2; sub = 1'b1; en = 1'b0;
    repeat (3) @(negedge clk);
    check("R3", "result held", result, 8'd44);
    check("R3", "carry held", flag_c, 1);
    check("R3", "aux held", flag_a, 0);
  endtask

  task automatic t_sweep();
    logic [7:0] x = 8'h5A, y = 8'hC3;
    for (int i = 0; i < 300; i++) begin
      x = {x[6:0], x[7] ^ x[5] ^ x[4] ^ x[3]};
      y = y + 8'd37 + x[2:0];
      do_op(x, y, i[0]);
      expect_op(x, y, i[0], "sweep");
    end
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; sub = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_four_cases();
    t_subtract();
    t_nibble();
    t_parity_zero();
    t_hold();
    t_sweep();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule